// File: doc/BRIEF.md
# Keyed-Service Watchdog Timer

This block is a system watchdog with three word-addressed registers on a simple write/read port. A configuration word sets the reload count, the enable, the action taken on expiry and an optional tick divider. That word can be written only once after power-on reset. A down-counter runs while the watchdog is enabled. Software must keep it from reaching zero by writing a fixed two-word key pair to the service register.

When the counter reaches zero, the block either pulses a reset request for one cycle or raises an interrupt. The interrupt stays high until a valid key pair is written. The current count can always be read back. A parameter lets the watchdog come out of reset already running; the single configuration write then still sets the timeout and the mode.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset, the configuration word reads as follows: bits 31:16 hold DEFAULT_TIMEOUT, bit 2 (enable) holds EN_AT_RESET, bit 1 (action select) is 1 and bit 0 (divider enable) is 0. The count register reads DEFAULT_TIMEOUT, and `rst_req` and `irq` are low. The word addresses are 0 for configuration, 1 for count and 2 for service.
- R2: The first write to address 0 stores bits 31:16, 2, 1 and 0 of the write data and loads the written timeout into the counter on the same edge. Every later write to address 0 has no effect, and readback keeps returning the stored word.
- R3: The enable bit cannot be cleared once it is 1. When EN_AT_RESET is 1, the configuration write leaves the enable bit at 1.
- R4: While the watchdog is disabled, the counter holds the reload value and does not count.
- R5: While enabled with bit 0 clear, the counter decrements once per clock and stops at zero.
- R6: While enabled with bit 0 set, the counter decrements once every PRESCALE_DIV clocks. The divider restarts on the configuration write and on every valid service.
- R7: A write of 0x556C to the low 16 bits of address 2, followed directly by a write of 0xAA39, reloads the counter from bits 31:16 and clears `irq`.
- R8: Any other service write breaks the pair, and a 0xAA39 write without a preceding 0x556C does not reload. A 0x556C write always arms the pair afresh.
- R9: With bit 1 set, on the edge where the counter reaches zero, `rst_req` is high for exactly one cycle.
- R10: With bit 1 clear, `irq` rises when the counter reaches zero, stays high until a valid service, and `rst_req` stays low.
- R11: Address 1 returns the current count in bits 15:0 and zeros above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous power-on reset |
| bus_wr | input | 1 | Write strobe, one write per asserted cycle |
| bus_addr | input | 2 | Word address for write and read |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| rst_req | output | 1 | One-cycle reset request on expiry |
| irq | output | 1 | Level interrupt on expiry |

## Verification
The checker assumes that `rst_n` is asserted from time zero. It also assumes that a configuration write never coincides with an expiry, because the write reloads the counter and replaces the action select on the same edge.

The stimulus follows both assumptions. Each instance is configured before its counter could reach zero, and every write is held for exactly one clock, driven at a falling edge. Because of this, each service word in the vector table advances the counter by one cycle, and the expected count follows directly from the table.

// File: rtl/kwd_pkg.sv
package kwd_pkg;
   localparam int TMO_W = 16;

   typedef struct packed {
      logic [TMO_W-1:0] timeout;
      logic [12:0]      rsvd;
      logic             en;
      logic             rst_sel;
      logic             pre;
   } cfg_t;

   localparam logic [1:0] ADDR_CFG = 2'd0;
   localparam logic [1:0] ADDR_CNT = 2'd1;
   localparam logic [1:0] ADDR_SVC = 2'd2;

   localparam logic [15:0] KEY_ARM  = 16'h556C;
   localparam logic [15:0] KEY_FIRE = 16'hAA39;
endpackage

// File: rtl/kwd_cfg_reg.sv
module kwd_cfg_reg
   import kwd_pkg::*;
#(
   parameter bit               EN_AT_RESET     = 1'b0,
   parameter logic [TMO_W-1:0] DEFAULT_TIMEOUT = 16'hFFFF
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [TMO_W-1:0] wr_timeout,
   input  logic             wr_en,
   input  logic             wr_sel,
   input  logic             wr_pre,
   output cfg_t             cfg,
   output logic             take,
   output logic             locked
);
   assign take = wr && !locked;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg.timeout <= DEFAULT_TIMEOUT;
         cfg.rsvd    <= '0;
         cfg.en      <= EN_AT_RESET;
         cfg.rst_sel <= 1'b1;
         cfg.pre     <= 1'b0;
         locked      <= 1'b0;
      end else if (take) begin
         cfg.timeout <= wr_timeout;
         cfg.en      <= EN_AT_RESET ? 1'b1 : wr_en;
         cfg.rst_sel <= wr_sel;
         cfg.pre     <= wr_pre;
         locked      <= 1'b1;
      end
   end
endmodule

// File: rtl/kwd_prescaler.sv
module kwd_prescaler #(
   parameter int DIV = 65536
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   input  logic pre_en,
   output logic tick
);
   localparam int  PW       = (DIV > 2) ? $clog2(DIV) : 1;
   localparam bit  IS_POW2  = ((DIV & (DIV - 1)) == 0);

   logic [PW-1:0] pcnt;
   logic          wrap;

   generate
      if (DIV < 2) begin : g_bad
         $error("kwd_prescaler: DIV must be at least 2");
      end
      if (IS_POW2) begin : g_pow2
         assign wrap = &pcnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       pcnt <= '0;
            else if (restart) pcnt <= '0;
            else              pcnt <= pcnt + 1'b1;
         end
      end else begin : g_cmp
         assign wrap = (pcnt == PW'(DIV - 1));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)             pcnt <= '0;
            else if (restart||wrap) pcnt <= '0;
            else                    pcnt <= pcnt + 1'b1;
         end
      end
   endgenerate

   assign tick = pre_en ? wrap : 1'b1;
endmodule

// File: rtl/kwd_key_seq.sv
module kwd_key_seq
   import kwd_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr,
   input  logic [15:0] wdata,
   output logic        svc_ok
);
   logic armed;

   assign svc_ok = wr && armed && (wdata == KEY_FIRE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  armed <= 1'b0;
      else if (wr) armed <= (wdata == KEY_ARM);
   end
endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
   import kwd_pkg::*;
#(
   parameter int               PRESCALE_DIV    = 65536,
   parameter bit               EN_AT_RESET     = 1'b0,
   parameter logic [TMO_W-1:0] DEFAULT_TIMEOUT = 16'hFFFF
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        bus_wr,
   input  logic [1:0]  bus_addr,
   input  logic [31:0] bus_wdata,
   output logic [31:0] bus_rdata,
   output logic        rst_req,
   output logic        irq
);
   generate
      if (DEFAULT_TIMEOUT == '0) begin : g_bad_tmo
         $error("keyed_watchdog: DEFAULT_TIMEOUT must be nonzero");
      end
   endgenerate

   cfg_t             cfg;
   logic             take, locked, tick, svc_ok, expire;
   logic [TMO_W-1:0] cnt_q;
   logic             rst_req_q, irq_q;
   wire              unused_wbits = ^bus_wdata[15:3];

   kwd_cfg_reg #(.EN_AT_RESET(EN_AT_RESET), .DEFAULT_TIMEOUT(DEFAULT_TIMEOUT)) u_cfg (
      .clk(clk), .rst_n(rst_n),
      .wr(bus_wr && bus_addr == ADDR_CFG),
      .wr_timeout(bus_wdata[31:16]), .wr_en(bus_wdata[2]),
      .wr_sel(bus_wdata[1]), .wr_pre(bus_wdata[0]),
      .cfg(cfg), .take(take), .locked(locked)
   );

   kwd_prescaler #(.DIV(PRESCALE_DIV)) u_pre (
      .clk(clk), .rst_n(rst_n), .restart(take || svc_ok),
      .pre_en(cfg.pre), .tick(tick)
   );

   kwd_key_seq u_key (
      .clk(clk), .rst_n(rst_n),
      .wr(bus_wr && bus_addr == ADDR_SVC),
      .wdata(bus_wdata[15:0]), .svc_ok(svc_ok)
   );

   assign expire = cfg.en && tick && (cnt_q == TMO_W'(1)) && !take && !svc_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q     <= DEFAULT_TIMEOUT;
         rst_req_q <= 1'b0;
         irq_q     <= 1'b0;
      end else begin
         if (take)                     cnt_q <= bus_wdata[31:16];
         else if (svc_ok || !cfg.en)   cnt_q <= cfg.timeout;
         else if (tick && cnt_q != '0) cnt_q <= cnt_q - 1'b1;

         rst_req_q <= expire && cfg.rst_sel;

         if (svc_ok)                       irq_q <= 1'b0;
         else if (expire && !cfg.rst_sel)  irq_q <= 1'b1;
      end
   end

   always_comb begin
      unique case (bus_addr)
         ADDR_CFG: bus_rdata = cfg;
         ADDR_CNT: bus_rdata = {{(32-TMO_W){1'b0}}, cnt_q};
         default:  bus_rdata = '0;
      endcase
   end

   assign rst_req = rst_req_q;
   assign irq     = irq_q;
endmodule

// File: rtl/kwd_checker.sv
module kwd_checker (
   input logic        clk,
   input logic        rst_n,
   input logic        rst_req,
   input logic        irq,
   input logic [15:0] cnt,
   input logic [31:0] cfg_word,
   input logic        locked,
   input logic        svc_ok,
   input logic        take
);
   a_r9_reset_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |=> !rst_req);

   a_r9_pulse_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |-> (cnt == 16'd0 && cfg_word[1]));

   a_r10_irq_mode_only: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> !cfg_word[1]);

   a_r10_irq_rise_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> cnt == 16'd0);

   a_r7_irq_clear_by_service: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq) |-> $past(svc_ok));

   a_r2_locked_stable: assert property (@(posedge clk) disable iff (!rst_n)
      $past(locked) |-> $stable(cfg_word));

   a_r3_enable_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      $past(cfg_word[2]) |-> cfg_word[2]);

   a_r5_no_rise_unless_load: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt > $past(cnt)) |-> ($past(svc_ok) || $past(take) || !$past(cfg_word[2])));
endmodule

bind keyed_watchdog kwd_checker u_chk (
   .clk(clk), .rst_n(rst_n), .rst_req(rst_req), .irq(irq), .cnt(cnt_q),
   .cfg_word(cfg), .locked(locked), .svc_ok(svc_ok), .take(take)
);

// File: tb/keyed_watchdog_bench.sv
module keyed_watchdog_bench;
   localparam int CLK_PERIOD = 10;
   localparam int DIV_TB     = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_a = 1'b0, wr_b = 1'b0;
   logic [1:0]  addr_a = 2'd0, addr_b = 2'd0;
   logic [31:0] wd_a = '0, wd_b = '0;
   logic [31:0] rd_a, rd_b;
   logic        rq_a, rq_b, irq_a, irq_b;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   keyed_watchdog #(.PRESCALE_DIV(DIV_TB), .EN_AT_RESET(1'b0)) u_keyed_watchdog (
      .clk(clk), .rst_n(rst_n), .bus_wr(wr_a), .bus_addr(addr_a), .bus_wdata(wd_a),
      .bus_rdata(rd_a), .rst_req(rq_a), .irq(irq_a));

   keyed_watchdog #(.PRESCALE_DIV(DIV_TB), .EN_AT_RESET(1'b1)) u_keyed_watchdog_on (
      .clk(clk), .rst_n(rst_n), .bus_wr(wr_b), .bus_addr(addr_b), .bus_wdata(wd_b),
      .bus_rdata(rd_b), .rst_req(rq_b), .irq(irq_b));

   // table: service word, expected count after its single-cycle write
   localparam int NV = 11;
   localparam logic [31:0] VEC [NV] = '{
      {16'hAA39, 16'd9}, {16'h556C, 16'd8}, {16'h1234, 16'd7}, {16'hAA39, 16'd6},
      {16'h556C, 16'd5}, {16'hAA39, 16'd10}, {16'h556C, 16'd9}, {16'h556C, 16'd8},
      {16'hAA39, 16'd10}, {16'h0000, 16'd9}, {16'hAA39, 16'd8}};

   task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s got=%h exp=%h", tag, got, exp);
      end
   endtask

   // called at a falling edge; returns at the next falling edge
   task automatic wr(input bit b, input logic [1:0] a, input logic [31:0] d);
      if (b) begin wr_b = 1'b1; addr_b = a; wd_b = d; end
      else   begin wr_a = 1'b1; addr_a = a; wd_a = d; end
      @(negedge clk);
      wr_a = 1'b0; wr_b = 1'b0;
   endtask

   task automatic rd(input bit b, input logic [1:0] a, output logic [31:0] v);
      if (b) addr_b = a; else addr_a = a;
      #1;
      v = b ? rd_b : rd_a;
   endtask

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog expired");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(0, 2'd0, v); check("R1 cfg A", v, 32'hFFFF0002);
      rd(0, 2'd1, v); check("R1 R11 count A", v, 32'h0000FFFF);
      check("R1 outputs A", {30'd0, rq_a, irq_a}, 32'd0);
      rd(1, 2'd0, v); check("R1 cfg B", v, 32'hFFFF0006);

      // R4 disabled holds
      repeat (10) @(negedge clk);
      rd(0, 2'd1, v); check("R4 disabled count", v, 32'h0000FFFF);

      // configure B first: timeout 3, enable 0 requested, reset mode, divider on
      wr(1, 2'd0, 32'h00030003);
      rd(1, 2'd0, v); check("R3 enable kept B", v, 32'h00030007);
      rd(1, 2'd1, v); check("R2 B loaded", v, 32'd3);
      repeat (3) @(negedge clk);
      rd(1, 2'd1, v); check("R6 B holds before tick", v, 32'd3);
      @(negedge clk);
      rd(1, 2'd1, v); check("R6 B first tick", v, 32'd2);
      repeat (7) @(negedge clk);
      rd(1, 2'd1, v); check("R6 B count 1", v, 32'd1);
      check("R9 no early pulse", {31'd0, rq_b}, 32'd0);
      @(negedge clk);
      rd(1, 2'd1, v); check("R9 B zero", v, 32'd0);
      check("R9 pulse high", {31'd0, rq_b}, 32'd1);
      @(negedge clk);
      check("R9 pulse one cycle", {31'd0, rq_b}, 32'd0);
      check("R9 no irq in reset mode", {31'd0, irq_b}, 32'd0);
      wr(1, 2'd0, 32'h00090000);
      rd(1, 2'd0, v); check("R2 B relock ignored", v, 32'h00030007);

      // A: timeout 10, enabled, interrupt mode, divider off
      wr(0, 2'd0, 32'h000A0004);
      rd(0, 2'd1, v); check("R2 A loaded", v, 32'd10);
      repeat (9) @(negedge clk);
      rd(0, 2'd1, v); check("R5 A count 1", v, 32'd1);
      check("R10 irq low before zero", {31'd0, irq_a}, 32'd0);
      @(negedge clk);
      rd(0, 2'd1, v); check("R5 A zero", v, 32'd0);
      check("R10 irq raised", {31'd0, irq_a}, 32'd1);
      repeat (5) @(negedge clk);
      rd(0, 2'd1, v); check("R5 stays zero", v, 32'd0);
      check("R10 irq held", {31'd0, irq_a}, 32'd1);
      check("R10 no reset pulse", {31'd0, rq_a}, 32'd0);
      wr(0, 2'd0, 32'h00050000);
      rd(0, 2'd0, v); check("R2 A relock ignored", v, 32'h000A0004);
      check("R3 A still enabled", {31'd0, v[2]}, 32'd1);

      // R7 valid service
      wr(0, 2'd2, 32'h0000556C);
      wr(0, 2'd2, 32'h0000AA39);
      rd(0, 2'd1, v); check("R7 reload", v, 32'd10);
      check("R7 irq cleared", {31'd0, irq_a}, 32'd0);

      // R8 vector table of service words
      for (int i = 0; i < NV; i++) begin
         wr(0, 2'd2, {16'd0, VEC[i][31:16]});
         rd(0, 2'd1, v);
         check($sformatf("R8 vec %0d", i), v, {16'd0, VEC[i][15:0]});
      end
      check("R8 irq stays low", {31'd0, irq_a}, 32'd0);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule